// File: doc/BRIEF.md
# GPIO Interrupt Source Selector

This block turns a wide bus of GPIO interrupt inputs into a fixed number of interrupt channels for a parent interrupt controller. Each channel picks one input bit through a 7-bit source index, passes it through a two-stage synchronizer and watches it for one of four programmable conditions: rising edge, falling edge, high level or low level. A detected event is recorded in a per-channel status bit. Each channel drives one active-high request line toward the parent.

Software sets up the block through a small word-addressed register port. The port has a write strobe and a combinational read. Source-select words pack four channels each, one byte per channel: bit 7 is the enable and bits 6..0 are the index. Sense words pack sixteen channels each, two bits per channel. One status word holds a bit per channel. Writing a 0 to a status bit acknowledges an edge event. A status bit in a level mode simply tracks the qualified level.

Any change to a channel's select byte or sense field restarts that channel's history for three cycles, so re-pointing a channel never produces a false edge.

Top module: `gpio_irq_sel`

## Requirements
- R1: After reset every register reads 0, every status bit is 0 and every `irq_out` bit is low.
- R2: Register map (byte offsets on `reg_addr`, low two bits ignored). Status is at 0x20, with bit n for channel n. Sense for channels 0..15 is at 0x24 and sense for channels 16..31 is at 0x28, each channel using bits [2*(n%16)+1 : 2*(n%16)]. Source select for channel n is at 0x30 + 4*(n/4), in byte n%4 of that word, with bit 7 the enable and bits 6..0 the index. Every field reads back what was written, and any other offset reads 0.
- R3: With sense 0 (rising edge), a 0-to-1 change on the selected input sets the status bit, and the matching `irq_out` bit goes high on the third rising clock edge after the input change.
- R4: With sense 1 (falling edge), a 1-to-0 change on the selected input sets the status bit with the same three-edge latency.
- R5: With sense 2 (high level), the status bit equals the synchronized input, three edges late. Writing 0 to the bit while the input is high leaves it at 1.
- R6: With sense 3 (low level), the status bit is 1 while the synchronized input is 0 and becomes 0 three edges after the input goes high.
- R7: In an edge mode the status bit stays set until a status write carries 0 in that bit position. A 1 in that position leaves the bit unchanged.
- R8: A channel whose enable bit is 0 never sets its status bit, and its `irq_out` bit stays low.
- R9: A write that changes a channel's select byte or sense field suppresses detection on that channel for the next three clock edges. Switching the source from a low input to a high input therefore raises no rising-edge event, while later real edges are still caught.
- R10: A channel reacts only to `gpio_in[index]`. Activity on any other input bit has no effect on it.
- R11: `irq_out[n]` is status bit n AND enable bit n. Clearing the enable drops the output at once, while the stored edge status remains readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 128 | GPIO interrupt input bus, asynchronous to clk |
| reg_we | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 7 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 32 | Per-channel active-high request to the parent controller |

## Verification
An input change reaches a status bit and `irq_out` on the third rising edge after it: two synchronizer flops plus the status flop. A status write or a register write takes effect on the same edge that samples `reg_we`, and reads are combinational. A configuration change masks detection on the three edges that follow it. The bench drives every input just after a falling edge and samples just before the next falling edge. A behavioural model advances on each rising edge and is compared against `irq_out` every cycle, and the directed checks count edges to land on the exact cycle each result is due.

// File: rtl/gpio_irq_sel_pkg.sv
package gpio_irq_sel_pkg;
  typedef enum logic [1:0] {
    SNS_RISE = 2'd0,
    SNS_FALL = 2'd1,
    SNS_HIGH = 2'd2,
    SNS_LOW  = 2'd3
  } sense_e;

  localparam int SRC_W      = 7;
  localparam int SRC_SPAN   = 1 << SRC_W;
  localparam int SYNC_DEPTH = 2;
  localparam int SETTLE_CYC = SYNC_DEPTH + 1;
  localparam int SETTLE_W   = $clog2(SETTLE_CYC + 1);

  localparam int ADDR_W      = 7;
  localparam int WORD_STATUS = 'h20 >> 2;
  localparam int WORD_SENSE0 = 'h24 >> 2;
  localparam int WORD_SEL0   = 'h30 >> 2;
  localparam int CH_PER_SEL  = 4;
  localparam int CH_PER_SNS  = 16;
endpackage

// File: rtl/gpio_irq_sel_regs.sv
module gpio_irq_sel_regs
  import gpio_irq_sel_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wdata,
  input  logic [NCH-1:0]               status,
  output logic [31:0]                  rdata,
  output logic [NCH*8-1:0]             sel_flat,
  output logic [NCH*2-1:0]             sns_flat,
  output logic [NCH-1:0]               clr,
  output logic [NCH-1:0]               chg
);
  logic [7:0] sel_q [NCH];
  logic [1:0] sns_q [NCH];
  logic [ADDR_W-3:0] word;

  assign word = addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sel_q[c] <= '0;
        sns_q[c] <= '0;
      end
    end else if (we) begin
      for (int c = 0; c < NCH; c++) begin
        if (int'(word) == WORD_SEL0 + c / CH_PER_SEL)
          sel_q[c] <= wdata[(c % CH_PER_SEL)*8 +: 8];
        if (int'(word) == WORD_SENSE0 + c / CH_PER_SNS)
          sns_q[c] <= wdata[(c % CH_PER_SNS)*2 +: 2];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chg[c] = we && (
                 ((int'(word) == WORD_SEL0 + c / CH_PER_SEL) &&
                  (wdata[(c % CH_PER_SEL)*8 +: 8] != sel_q[c])) ||
                 ((int'(word) == WORD_SENSE0 + c / CH_PER_SNS) &&
                  (wdata[(c % CH_PER_SNS)*2 +: 2] != sns_q[c])));
      clr[c] = we && (int'(word) == WORD_STATUS) && !wdata[c];
      sel_flat[c*8 +: 8] = sel_q[c];
      sns_flat[c*2 +: 2] = sns_q[c];
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(word) == WORD_STATUS) rdata[NCH-1:0] = status;
    for (int c = 0; c < NCH; c++) begin
      if (int'(word) == WORD_SEL0 + c / CH_PER_SEL)
        rdata[(c % CH_PER_SEL)*8 +: 8] = sel_q[c];
      if (int'(word) == WORD_SENSE0 + c / CH_PER_SNS)
        rdata[(c % CH_PER_SNS)*2 +: 2] = sns_q[c];
    end
  end
endmodule

// File: rtl/gpio_irq_sel_chan.sv
module gpio_irq_sel_chan
  import gpio_irq_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_SPAN-1:0] gpio,
  input  logic [SRC_W-1:0]    src,
  input  logic                en,
  input  logic [1:0]          sense,
  input  logic                clr,
  input  logic                chg,
  output logic                status
);
  localparam logic [SETTLE_W-1:0] SETTLE_LOAD = SETTLE_W'(SETTLE_CYC);

  logic [SYNC_DEPTH-1:0] sync_q;
  logic                  prev_q;
  logic [SETTLE_W-1:0]   settle_q;
  logic                  now_v, qual, edge_hit, lvl_hit, status_d;
  sense_e                mode;

  assign mode  = sense_e'(sense);
  assign now_v = sync_q[SYNC_DEPTH-1];
  assign qual  = en && (settle_q == '0);

  always_comb begin
    edge_hit = 1'b0;
    lvl_hit  = 1'b0;
    unique case (mode)
      SNS_RISE: edge_hit = now_v && !prev_q;
      SNS_FALL: edge_hit = !now_v && prev_q;
      SNS_HIGH: lvl_hit  = now_v;
      SNS_LOW:  lvl_hit  = !now_v;
      default:  edge_hit = 1'b0;
    endcase
    if (mode == SNS_HIGH || mode == SNS_LOW)
      status_d = qual && lvl_hit;
    else
      status_d = (status && !clr) || (qual && edge_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      settle_q <= '0;
      status   <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_DEPTH-2:0], gpio[src]};
      prev_q   <= now_v;
      status   <= status_d;
      if (chg)
        settle_q <= SETTLE_LOAD;
      else if (settle_q != '0)
        settle_q <= settle_q - 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_sel.sv
module gpio_irq_sel
  import gpio_irq_sel_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int NSRC = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      gpio_in,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [NCH-1:0]       irq_out
);
  logic [SRC_SPAN-1:0] gpio_ext;
  logic [NCH*8-1:0]    sel_flat;
  logic [NCH*2-1:0]    sns_flat;
  logic [NCH-1:0]      status_vec, en_vec, lvl_vec, clr_vec, chg_vec;

  always_comb begin
    gpio_ext = '0;
    gpio_ext[NSRC-1:0] = gpio_in;
  end

  gpio_irq_sel_regs #(.NCH(NCH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .status   (status_vec),
    .rdata    (reg_rdata),
    .sel_flat (sel_flat),
    .sns_flat (sns_flat),
    .clr      (clr_vec),
    .chg      (chg_vec)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign en_vec[c]  = sel_flat[c*8 + 7];
    assign lvl_vec[c] = sns_flat[c*2 + 1];

    gpio_irq_sel_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .gpio   (gpio_ext),
      .src    (sel_flat[c*8 +: SRC_W]),
      .en     (en_vec[c]),
      .sense  (sns_flat[c*2 +: 2]),
      .clr    (clr_vec[c]),
      .chg    (chg_vec[c]),
      .status (status_vec[c])
    );
  end

  assign irq_out = status_vec & en_vec;
endmodule

// File: rtl/gpio_irq_sel_chk.sv
module gpio_irq_sel_chk
  import gpio_irq_sel_pkg::*;
#(
  parameter int NCH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    irq_out,
  input logic [NCH-1:0]    status,
  input logic [NCH-1:0]    en,
  input logic [NCH-1:0]    clr,
  input logic [NCH-1:0]    lvl,
  input logic [NCH-1:0]    chg,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata
);
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~en) == '0); // R8

  AST_NO_SET_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(en)) == '0); // R8

  AST_NO_SET_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & $past(chg)) == '0); // R9

  AST_EDGE_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (~status & $past(status) & ~$past(clr) & ~$past(lvl)) == '0); // R7

  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr[ADDR_W-1:2]) == WORD_STATUS) |-> (rdata[NCH-1:0] == status)); // R2

  AST_IRQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~status) == '0); // R11
endmodule

bind gpio_irq_sel gpio_irq_sel_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_out (irq_out),
  .status  (status_vec),
  .en      (en_vec),
  .clr     (clr_vec),
  .lvl     (lvl_vec),
  .chg     (chg_vec),
  .addr    (reg_addr),
  .rdata   (reg_rdata)
);

// File: tb/gpio_irq_sel_tb.sv
`timescale 1ns/1ps
module gpio_irq_sel_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] gpio = '0;
  logic         reg_we = 1'b0;
  logic [6:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [31:0]  irq_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  gpio_irq_sel u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpio_in   (gpio),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  // Behavioural reference model
  logic [7:0]  m_sel [32];
  logic [1:0]  m_sns [32];
  logic [31:0] m_st;
  bit          h1 [32];
  bit          h2 [32];
  bit          h3 [32];
  int          age [32];
  bit          m_q, m_clr, m_edge;
  logic [7:0]  m_nb;
  logic [1:0]  m_ns;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = '0;
      for (int c = 0; c < 32; c++) begin
        m_sel[c] = '0; m_sns[c] = '0;
        h1[c] = 0; h2[c] = 0; h3[c] = 0; age[c] = 4;
      end
    end else begin
      for (int c = 0; c < 32; c++) begin
        if (age[c] < 100) age[c]++;
        m_q   = m_sel[c][7] && (age[c] >= 4);
        m_clr = reg_we && (reg_addr[6:2] == 5'd8) && !reg_wdata[c];
        if (m_sns[c][1]) begin
          m_st[c] = m_q && ((m_sns[c] == 2'd2) ? h2[c] : !h2[c]);
        end else begin
          m_edge  = (m_sns[c] == 2'd0) ? (h2[c] && !h3[c]) : (!h2[c] && h3[c]);
          m_st[c] = (m_st[c] && !m_clr) || (m_q && m_edge);
        end
        h3[c] = h2[c];
        h2[c] = h1[c];
        h1[c] = gpio[m_sel[c][6:0]];
      end
      if (reg_we) begin
        for (int c = 0; c < 32; c++) begin
          if (int'(reg_addr[6:2]) == 12 + c / 4) begin
            m_nb = reg_wdata[(c % 4)*8 +: 8];
            if (m_nb != m_sel[c]) age[c] = 0;
            m_sel[c] = m_nb;
          end
          if (int'(reg_addr[6:2]) == 9 + c / 16) begin
            m_ns = reg_wdata[(c % 16)*2 +: 2];
            if (m_ns != m_sns[c]) age[c] = 0;
            m_sns[c] = m_ns;
          end
        end
      end
    end
  end

  function automatic logic [31:0] model_irq();
    logic [31:0] v;
    for (int c = 0; c < 32; c++) v[c] = m_st[c] & m_sel[c][7];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison of irq_out against the model (R11)
  always @(negedge clk) begin
    if (rst_n) chk("R11 irq_out vs model", irq_out, model_irq());
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    chk("R1 irq_out after reset", irq_out, 32'h0);
    rd("R1 status", 7'h20, 32'h0);
    rd("R1 sense0", 7'h24, 32'h0);
    rd("R1 sense1", 7'h28, 32'h0);
    rd("R1 sel0", 7'h30, 32'h0);
    rd("R1 sel7", 7'h4C, 32'h0);

    // R2: register map readback
    wr(7'h4C, 32'h8A05007F);
    rd("R2 sel7 readback", 7'h4C, 32'h8A05007F);
    wr(7'h28, 32'hC0000003);
    rd("R2 sense1 readback", 7'h28, 32'hC0000003);
    wr(7'h4C, 32'h0);
    wr(7'h28, 32'h0);
    rd("R2 unmapped 0x04", 7'h04, 32'h0);
    rd("R2 unmapped 0x2C", 7'h2C, 32'h0);
    rd("R2 sel7 cleared", 7'h4C, 32'h0);

    // channels 0..3: rise src5, fall src6, high src7, low src8
    gpio[6] = 1'b1;
    wr(7'h24, 32'h000000E4);
    wr(7'h30, 32'h88878685);
    idle(6);
    rd("R6 low level sets status", 7'h20, 32'h00000008);

    // R3: rising edge latency
    gpio[5] = 1'b1;
    idle(2);
    chk("R3 before third edge", {31'b0, irq_out[0]}, 32'h0);
    idle(1);
    chk("R3 on third edge", {31'b0, irq_out[0]}, 32'h1);
    gpio[5] = 1'b0;
    idle(4);
    chk("R7 edge status holds", {31'b0, irq_out[0]}, 32'h1);

    // R7: write 1 keeps, write 0 clears
    wr(7'h20, 32'hFFFFFFFF);
    chk("R7 write one keeps", {31'b0, irq_out[0]}, 32'h1);
    wr(7'h20, 32'hFFFFFFFE);
    chk("R7 write zero clears", {31'b0, irq_out[0]}, 32'h0);

    // R4: falling edge
    gpio[6] = 1'b0;
    idle(2);
    chk("R4 before third edge", {31'b0, irq_out[1]}, 32'h0);
    idle(1);
    chk("R4 falling edge", {31'b0, irq_out[1]}, 32'h1);

    // R5: high level, clear ineffective while asserted
    gpio[7] = 1'b1;
    idle(3);
    chk("R5 high level", {31'b0, irq_out[2]}, 32'h1);
    wr(7'h20, 32'hFFFFFFFB);
    idle(2);
    chk("R5 clear while high", {31'b0, irq_out[2]}, 32'h1);
    gpio[7] = 1'b0;
    idle(3);
    chk("R5 level drops", {31'b0, irq_out[2]}, 32'h0);

    // R6: low level released
    gpio[8] = 1'b1;
    idle(3);
    chk("R6 low level released", {31'b0, irq_out[3]}, 32'h0);

    // R8: disabled channel 4 on src9
    wr(7'h34, 32'h00000009);
    idle(6);
    gpio[9] = 1'b1;
    idle(5);
    chk("R8 disabled irq", {31'b0, irq_out[4]}, 32'h0);
    rd("R8 disabled status", 7'h20, {m_st[31:5], 1'b0, m_st[3:0]});
    chk("R8 status bit4", {31'b0, reg_rdata[4]}, 32'h0);

    // R11: enable gates the output, status remains
    gpio[5] = 1'b1;
    idle(3);
    chk("R11 ch0 raised", {31'b0, irq_out[0]}, 32'h1);
    wr(7'h30, 32'h88878605);
    chk("R11 disabled output low", {31'b0, irq_out[0]}, 32'h0);
    rd("R11 status kept", 7'h20, m_st);
    chk("R11 status bit0", {31'b0, reg_rdata[0]}, 32'h1);
    wr(7'h30, 32'h88878685);
    chk("R11 re-enabled output", {31'b0, irq_out[0]}, 32'h1);

    // R9: source switch from low input to high input
    gpio[10] = 1'b1;
    wr(7'h34, 32'h00008B09);
    idle(6);
    chk("R9 idle on src11", {31'b0, irq_out[5]}, 32'h0);
    wr(7'h34, 32'h00008A09);
    idle(6);
    chk("R9 no spurious edge", {31'b0, irq_out[5]}, 32'h0);
    gpio[10] = 1'b0;
    idle(2);
    gpio[10] = 1'b1;
    idle(3);
    chk("R9 real edge after settle", {31'b0, irq_out[5]}, 32'h1);

    // R10: only the selected input matters
    wr(7'h34, 32'h008C8A09);
    idle(6);
    gpio[13] = 1'b1;
    idle(4);
    chk("R10 other input ignored", {31'b0, irq_out[6]}, 32'h0);
    gpio[12] = 1'b1;
    idle(3);
    chk("R10 selected input", {31'b0, irq_out[6]}, 32'h1);

    rd("R2 final status vs model", 7'h20, m_st);
    idle(2);
    finish_run();
  end
endmodule